// File: doc/BRIEF.md
# Indirect Memory Access Host Port

This block is an 8-bit register port through which a host reaches a large address space using only four directly decoded registers. The host loads a 9-bit pointer and a space select, then moves bytes through a single data window register. The window reaches one of four spaces: switch data memory, the low byte of connection memory, the high byte of connection memory, or the internal control registers. A small request/acknowledge back end performs the actual memory cycle.

Accesses to the four direct registers complete in the strobe cycle, and the ready output stays high. A window access that hits a valid address raises a memory request and holds ready low until the back end acknowledges. After each window access the pointer and the space select advance according to rules that depend on the selected space. This lets software stream through data memory, or through low/high byte pairs of connection memory, without reloading the pointer.

Top module: `ind_host_port`

## Requirements
- R1: `bus_addr` selects the register of a strobe: 0 is an 8-bit read/write control register, 1 is the pointer low byte, 2 is the mode register, and 3 is the data window.
- R2: The mode register holds the following fields. Bit 7 enables auto-increment after window writes. Bit 6 enables auto-increment after window reads. Bits 2:1 select the space: 00 is data memory, 01 is connection low, 10 is connection high, and 11 is internal registers. Bit 0 is pointer bit 8. Bits 5:3 always read as zero. Reading register 1 or 2 returns the current pointer and select, including changes made by auto-advance.
- R3: After reset, the control register, pointer, space select and both increment enables are zero, `bus_ready` is high, and `mem_req` is low.
- R4: A strobe to register 0, 1 or 2 completes at once: `bus_ready` stays high, and read data appears on `bus_rdata` from the cycle after the strobe.
- R5: A window access to a pointer of 383 or less drives `mem_req` from the cycle after the strobe until the cycle after `mem_ack`. During that time `mem_addr`, `mem_space`, `mem_we` and `mem_wdata` hold steady, and `bus_ready` is low. A read returns `mem_rdata` on `bus_rdata`.
- R6: In data memory, a window access adds one to the pointer when the increment enable for its direction is set. Otherwise the pointer stays unchanged.
- R7: A window access in connection low always switches the select to connection high, with or without auto-increment, and leaves the pointer unchanged.
- R8: A window access in connection high with the increment enable for its direction set adds one to the pointer and switches back to connection low. Without that enable, both the pointer and the select stay unchanged.
- R9: Window accesses in the internal register space never change the pointer or the select.
- R10: A window access to a pointer above 383 raises no memory request and keeps `bus_ready` high. A write of this kind changes nothing. A read of this kind returns 0x00. The pointer still advances by the rules for its space.
- R11: Auto-increment wraps the 9-bit pointer from 511 to 0.
- R12: A strobe that arrives while `bus_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Direct register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the last completed read |
| bus_ready | output | 1 | High when no memory cycle is pending |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_space | output | 2 | Target space of the cycle |
| mem_addr | output | 9 | Target address of the cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | One-cycle completion from the back end |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |

## Verification
The assertions check on every cycle the back-end handshake: the request holds until acknowledged, its fields stay stable, it is released together with ready, and it is never raised above the range limit. They also check that direct strobes never drop ready, that a connection-low access always hands over to connection high, and that internal register accesses leave the pointer untouched. Only the bench scenarios can show the pointer arithmetic that depends on the increment enables: wrap-around, pairing of low and high bytes, and out-of-range reads returning zero. The same holds for ignored writes and for the byte-accurate routing of data to each space. The bench checks these against a reference memory image.

// File: rtl/ihp_pkg.sv
package ihp_pkg;
  typedef enum logic [1:0] {
    SP_DATA = 2'b00,
    SP_CLO  = 2'b01,
    SP_CHI  = 2'b10,
    SP_INT  = 2'b11
  } space_t;

  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_LOW  = 2'd1;
  localparam logic [1:0] RG_MODE = 2'd2;
  localparam logic [1:0] RG_WIN  = 2'd3;
endpackage

// File: rtl/ihp_ptr_next.sv
module ihp_ptr_next
  import ihp_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] ptr_i,
  input  space_t        sp_i,
  input  logic          is_wr_i,
  input  logic          inc_rd_i,
  input  logic          inc_wr_i,
  output logic [AW-1:0] ptr_o,
  output space_t        sp_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic inc_en;
  assign inc_en = is_wr_i ? inc_wr_i : inc_rd_i;

  always_comb begin
    ptr_o = ptr_i;
    sp_o  = sp_i;
    unique case (sp_i)
      SP_DATA: if (inc_en) ptr_o = ptr_i + ONE;
      SP_CLO:  sp_o = SP_CHI;
      SP_CHI: begin
        if (inc_en) begin
          ptr_o = ptr_i + ONE;
          sp_o  = SP_CLO;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ihp_seq.sv
module ihp_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (start_i)     busy_d = 1'b1;
    else if (done_i) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ind_host_port.sv
module ind_host_port
  import ihp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 9,
  parameter int LIMIT = 384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_stb,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_space,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int HI_W    = AW - DW;
  localparam int SEL_LSB = HI_W;
  localparam int IRD_BIT = DW - 2;
  localparam int IWR_BIT = DW - 1;

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [AW-1:0] ptr_q, ptr_d, ptr_nx;
  space_t        sp_q, sp_d, sp_nx;
  logic          inc_rd_q, inc_rd_d, inc_wr_q, inc_wr_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          wr_q, wr_d;
  logic          busy, accept, is_win, in_rng;
  logic          start, oor_done, mem_done, dir;
  logic [DW-1:0] mode_rd;

  generate
    if (LIMIT >= (1 << AW)) begin : g_full
      assign in_rng = 1'b1;
    end else begin : g_lim
      localparam logic [AW:0] LIM_V = (AW+1)'(LIMIT);
      assign in_rng = ({1'b0, ptr_q} < LIM_V);
    end
  endgenerate

  assign accept   = bus_stb && !busy;
  assign is_win   = (bus_addr == RG_WIN);
  assign start    = accept && is_win && in_rng;
  assign oor_done = accept && is_win && !in_rng;
  assign mem_done = busy && mem_ack;
  assign dir      = busy ? wr_q : bus_wr;

  ihp_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .done_i  (mem_done),
    .busy_o  (busy)
  );

  ihp_ptr_next #(.AW(AW)) u_next (
    .ptr_i    (ptr_q),
    .sp_i     (sp_q),
    .is_wr_i  (dir),
    .inc_rd_i (inc_rd_q),
    .inc_wr_i (inc_wr_q),
    .ptr_o    (ptr_nx),
    .sp_o     (sp_nx)
  );

  always_comb begin
    mode_rd                  = '0;
    mode_rd[IWR_BIT]         = inc_wr_q;
    mode_rd[IRD_BIT]         = inc_rd_q;
    mode_rd[SEL_LSB +: 2]    = sp_q;
    mode_rd[HI_W-1:0]        = ptr_q[AW-1:DW];
  end

  always_comb begin
    ctrl_d   = ctrl_q;
    ptr_d    = ptr_q;
    sp_d     = sp_q;
    inc_rd_d = inc_rd_q;
    inc_wr_d = inc_wr_q;
    rdata_d  = rdata_q;
    wdata_d  = wdata_q;
    wr_d     = wr_q;
    if (accept) begin
      unique case (bus_addr)
        RG_CTRL: begin
          if (bus_wr) ctrl_d = bus_wdata;
          else        rdata_d = ctrl_q;
        end
        RG_LOW: begin
          if (bus_wr) ptr_d[DW-1:0] = bus_wdata;
          else        rdata_d = ptr_q[DW-1:0];
        end
        RG_MODE: begin
          if (bus_wr) begin
            inc_wr_d       = bus_wdata[IWR_BIT];
            inc_rd_d       = bus_wdata[IRD_BIT];
            sp_d           = space_t'(bus_wdata[SEL_LSB +: 2]);
            ptr_d[AW-1:DW] = bus_wdata[HI_W-1:0];
          end else begin
            rdata_d = mode_rd;
          end
        end
        default: begin
          wr_d    = bus_wr;
          wdata_d = bus_wdata;
          if (!in_rng) begin
            if (!bus_wr) rdata_d = '0;
            ptr_d = ptr_nx;
            sp_d  = sp_nx;
          end
        end
      endcase
    end
    if (mem_done) begin
      if (!wr_q) rdata_d = mem_rdata;
      ptr_d = ptr_nx;
      sp_d  = sp_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ptr_q    <= '0;
      sp_q     <= SP_DATA;
      inc_rd_q <= 1'b0;
      inc_wr_q <= 1'b0;
      rdata_q  <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      ptr_q    <= ptr_d;
      sp_q     <= sp_d;
      inc_rd_q <= inc_rd_d;
      inc_wr_q <= inc_wr_d;
      rdata_q  <= rdata_d;
      wdata_q  <= wdata_d;
      wr_q     <= wr_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_ready = !busy;
  assign mem_req   = busy;
  assign mem_we    = wr_q;
  assign mem_space = sp_q;
  assign mem_addr  = ptr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/ind_host_port_chk.sv
module ind_host_port_chk #(
  parameter int DW    = 8,
  parameter int AW    = 9,
  parameter int LIMIT = 384
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_stb,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_space,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [DW-1:0] mem_rdata
);
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);

  a_r5_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_space)
                            && $stable(mem_we) && $stable(mem_wdata));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req && bus_ready);

  a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_addr) < LIMIT));

  a_r4_direct_fast: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && bus_ready && (bus_addr != 2'd3) |=> bus_ready);

  a_r7_low_to_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_space == 2'b01) |=> mem_space == 2'b10);

  a_r9_internal_still: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_space == 2'b11)
    |=> $stable(mem_addr) && (mem_space == 2'b11));
endmodule

bind ind_host_port ind_host_port_chk #(.DW(DW), .AW(AW), .LIMIT(LIMIT)) chk_i (.*);

// File: tb/ind_host_port_tb_top.sv
module ind_host_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 384;

  logic       clk, rst_n;
  logic       bus_stb, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_ready;
  logic       mem_req, mem_we, mem_ack;
  logic [1:0] mem_space;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0;
  int bad = 0;
  int req_count = 0;
  int lat_force = -1;
  int cnt = 0;

  logic [7:0] mem_arr [0:4*LIM-1];
  logic [7:0] exp_mem [0:4*LIM-1];

  int       m_ptr;
  int       m_sp;
  bit       m_ir, m_iw;
  bit [7:0] m_ctrl;

  ind_host_port dut_i (
    .clk, .rst_n, .bus_stb, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .bus_ready, .mem_req, .mem_we, .mem_space, .mem_addr, .mem_wdata,
    .mem_ack, .mem_rdata
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // back-end responder with variable latency
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (cnt <= 0) begin
          int idx;
          idx = int'(mem_space) * LIM + int'(mem_addr);
          if (mem_we) mem_arr[idx] = mem_wdata;
          mem_rdata = mem_arr[idx];
          mem_ack = 1'b1;
          req_count++;
          cnt = (lat_force >= 0) ? lat_force : int'($urandom % 4);
        end else begin
          cnt--;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic [1:0] a, input logic w, input logic [7:0] d,
                        output logic [7:0] q, output logic rdy_after);
    @(negedge clk);
    bus_stb = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0;
    rdy_after = bus_ready;
    while (!bus_ready) @(negedge clk);
    q = bus_rdata;
  endtask

  function automatic bit [7:0] m_mode();
    bit [7:0] v;
    v = {m_iw, m_ir, 3'b000, 2'(m_sp), 1'(m_ptr >> 8)};
    return v;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q; logic r;
    bus_op(a, 1'b1, d, q, r);
    if (a == 2'd0) m_ctrl = d;
    if (a == 2'd1) m_ptr = (m_ptr & 256) | int'(d);
    if (a == 2'd2) begin
      m_iw = d[7]; m_ir = d[6]; m_sp = int'(d[2:1]);
      m_ptr = (m_ptr & 255) | (int'(d[0]) << 8);
    end
  endtask

  task automatic check_ptr(input string tag);
    logic [7:0] q; logic r;
    bus_op(2'd1, 1'b0, 8'h00, q, r);
    chk({tag, " ptr low"}, int'(q), m_ptr & 255);
    bus_op(2'd2, 1'b0, 8'h00, q, r);
    chk({tag, " mode"}, int'(q), int'(m_mode()));
  endtask

  task automatic win_op(input logic w, input logic [7:0] d);
    logic [7:0] q; logic r;
    bit inr, inc;
    int idx, exp;
    string tag;
    inr = (m_ptr < LIM);
    idx = m_sp * LIM + m_ptr;
    case (m_sp)
      0: tag = "R6";
      1: tag = "R7";
      2: tag = "R8";
      default: tag = "R9";
    endcase
    if (!inr) tag = "R10";
    exp = inr ? int'(exp_mem[idx]) : 0;
    if (w && inr) exp_mem[idx] = d;
    bus_op(2'd3, w, d, q, r);
    chk({tag, " ready after window strobe (R5)"}, int'(r), inr ? 0 : 1);
    if (!w) chk({tag, " window read data (R5)"}, int'(q), exp);
    inc = w ? m_iw : m_ir;
    case (m_sp)
      0: if (inc) m_ptr = (m_ptr + 1) % 512;
      1: m_sp = 2;
      2: if (inc) begin m_ptr = (m_ptr + 1) % 512; m_sp = 1; end
      default: ;
    endcase
  endtask

  initial begin
    logic [7:0] q;
    logic r;
    int rc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4*LIM; i++) begin
      mem_arr[i] = 8'((i * 37 + 11) ^ (i >> 3));
      exp_mem[i] = mem_arr[i];
    end
    bus_stb = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ptr = 0; m_sp = 0; m_ir = 0; m_iw = 0; m_ctrl = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    @(negedge clk);
    chk("R3 ready after reset", int'(bus_ready), 1);
    chk("R3 no request after reset", int'(mem_req), 0);
    bus_op(2'd0, 1'b0, 8'h00, q, r);
    chk("R3 control reset", int'(q), 0);
    check_ptr("R3");

    // R1 / R4 control register
    bus_op(2'd0, 1'b1, 8'hA5, q, r);
    m_ctrl = 8'hA5;
    chk("R4 ready on direct write", int'(r), 1);
    bus_op(2'd0, 1'b0, 8'h00, q, r);
    chk("R1 control readback", int'(q), 8'hA5);
    chk("R4 ready on direct read", int'(r), 1);

    // R2 mode layout, bits 5:3 read zero
    wr_reg(2'd2, 8'hFD);
    check_ptr("R2");

    // R6 data memory with write increment
    wr_reg(2'd1, 8'd10); wr_reg(2'd2, 8'h80);
    win_op(1'b1, 8'h11); win_op(1'b1, 8'h22); win_op(1'b1, 8'h33);
    check_ptr("R6 write inc");
    wr_reg(2'd1, 8'd10); wr_reg(2'd2, 8'h00);
    win_op(1'b0, 8'h00); win_op(1'b0, 8'h00);
    check_ptr("R6 no inc");
    wr_reg(2'd2, 8'h40);
    win_op(1'b0, 8'h00); win_op(1'b0, 8'h00); win_op(1'b0, 8'h00);
    check_ptr("R6 read inc");

    // R7 / R8 connection memory without increment
    wr_reg(2'd1, 8'd50); wr_reg(2'd2, 8'h02);
    win_op(1'b1, 8'h5A);
    check_ptr("R7 low to high");
    win_op(1'b1, 8'h6B); win_op(1'b1, 8'h7C);
    check_ptr("R8 stays high");
    // R8 with increment: low,high,low,high
    wr_reg(2'd1, 8'd20); wr_reg(2'd2, 8'h82);
    win_op(1'b1, 8'h01); win_op(1'b1, 8'h02); win_op(1'b1, 8'h03); win_op(1'b1, 8'h04);
    check_ptr("R8 paired advance");
    wr_reg(2'd1, 8'd20); wr_reg(2'd2, 8'h42);
    for (int k = 0; k < 4; k++) win_op(1'b0, 8'h00);
    check_ptr("R8 paired read");

    // R9 internal space never moves
    wr_reg(2'd1, 8'd7); wr_reg(2'd2, 8'hC6);
    win_op(1'b1, 8'h99); win_op(1'b0, 8'h00);
    check_ptr("R9");

    // R10 out of range
    rc = req_count;
    wr_reg(2'd1, 8'h80); wr_reg(2'd2, 8'hC1);
    win_op(1'b1, 8'h55); win_op(1'b0, 8'h00);
    chk("R10 no request issued", req_count, rc);
    check_ptr("R10 pointer advance");

    // R11 wrap 511 -> 0
    wr_reg(2'd1, 8'hFF); wr_reg(2'd2, 8'hC1);
    win_op(1'b0, 8'h00);
    check_ptr("R11 wrap");
    win_op(1'b0, 8'h00);

    // R12 strobe during busy is ignored
    lat_force = 4;
    wr_reg(2'd1, 8'd3); wr_reg(2'd2, 8'h00);
    @(negedge clk);
    bus_stb = 1'b1; bus_wr = 1'b0; bus_addr = 2'd3;
    @(negedge clk);
    chk("R12 busy before second strobe", int'(bus_ready), 0);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h3C;
    @(negedge clk);
    bus_stb = 1'b0;
    while (!bus_ready) @(negedge clk);
    chk("R12 read data intact", int'(bus_rdata), int'(exp_mem[3]));
    bus_op(2'd0, 1'b0, 8'h00, q, r);
    chk("R12 control unchanged", int'(q), int'(m_ctrl));
    lat_force = -1;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: wr_reg(2'd1, 8'($urandom));
        1: wr_reg(2'd2, 8'($urandom));
        2, 3: win_op(1'b1, 8'($urandom));
        4, 5: win_op(1'b0, 8'h00);
        6: begin
          wr_reg(2'd0, 8'($urandom));
          bus_op(2'd0, 1'b0, 8'h00, q, r);
          chk("R1 random control", int'(q), int'(m_ctrl));
        end
        default: check_ptr("R2 random");
      endcase
    end
    check_ptr("R6 final");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule